// File: doc/BRIEF.md
# Six-Channel Paired PWM Generator

A pulse-width modulation timer that drives six outputs from one shared 16-bit counter. The outputs form three pairs, and both channels of a pair take their duty from one compare value. A prescaler slows the counting rate. The counter runs either as a down counter, which gives edge-aligned pulses, or as an up-down counter, which gives center-aligned pulses. A pair mode sets how the odd channel of each pair relates to its even partner.

Software programs the block through a single write port that carries a write enable, a 4-bit address and 16 bits of data. Period and compare values go into holding buffers. They reach the counter only when a load is requested, and only at the counter's next zero point, so a pulse already in progress is never cut short. A per-channel mask can force any output to a fixed level, and one inverter bit flips all six pins. A sticky period flag raises an interrupt. Software chooses whether the flag marks the counter reaching zero or the counter turning at the period value.

Top module: `pwm_pair_gen`

## Requirements
- R1: After reset all six outputs are low, the interrupt flag is low, and the counter stays stopped until a run bit is written.
- R2: The prescale field CFG[1:0] (address 0) sets the clocks per counter step: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 16.
- R3: With CFG[2]=0 the counter steps down from the period value P to 0 and then reloads, so one period lasts P+1 steps. A channel is high while the counter is at or below its pair's compare value C, which is min(C,P)+1 steps per period.
- R4: With CFG[2]=1 the counter steps up from 0 to P and back down, so one period lasts 2P steps. A channel is high for 2C+1 steps when C<P, and for the whole period otherwise.
- R5: Compare register k (address 8+k, k=0..2) sets the duty of both channel 2k and channel 2k+1.
- R6: Writes to the period buffer (address 3) and the compare buffers have no effect on the outputs until address 6 is written. The buffered values then take effect at the next zero point of the counter.
- R7: A period value of 0, once loaded, holds the counter at 0.
- R8: Pair mode CFG[4:3] sets the odd channel. Code 0 (independent): the odd channel outputs the pair's waveform, gated by its own enable. Code 1 (complementary): the odd channel outputs the inverse of the pair's waveform, gated by its own enable. Code 2 (synchronized): the odd channel copies the even channel, including the even channel's gating.
- R9: Channel n drives its waveform only when bit n is set in both the run register (address 1) and the output-enable register (address 2). Otherwise it drives low before masking and inversion. The counter runs while any run bit is set, and clearing every run bit returns it to 0.
- R10: When bit n of the mask-enable register (address 4) is set, channel n drives bit n of the mask-level register (address 5) in place of its waveform.
- R11: When CFG[6] is set, all six outputs are inverted. The inversion is applied after masking.
- R12: When CFG[5]=0 the flag sets on the counter step from 1 down to 0. When CFG[5]=1 it sets on the step that leaves the period value (counter equal to P, P not 0).
- R13: The flag stays set until a write to address 7 with data bit 0 set. A set event in the same cycle as that write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Register write data |
| pwm_o | output | 6 | PWM outputs, bit n is channel n |
| irq_o | output | 1 | Sticky period interrupt flag |

## Verification
The prescaler-spacing property assumes that the prescale code, counting type and pair mode change only while every run bit is clear. The bench therefore clears the run register before each reconfiguration and sets it again afterwards. Writes arrive at most one per cycle, and each is held for exactly one clock. Duty checks count high samples over a whole number of periods, so the phase at which a measurement starts does not matter.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned PS_W   = 4;

  typedef enum logic [1:0] {
    MODE_INDEP = 2'd0,
    MODE_COMPL = 2'd1,
    MODE_SYNC  = 2'd2,
    MODE_RSVD  = 2'd3
  } pair_mode_e;

  typedef struct packed {
    logic       invert;
    logic       irq_on_match;
    pair_mode_e mode;
    logic       center;
    logic [1:0] div;
  } cfg_t;

  localparam logic [ADDR_W-1:0] A_CFG    = 4'd0;
  localparam logic [ADDR_W-1:0] A_RUN    = 4'd1;
  localparam logic [ADDR_W-1:0] A_OEN    = 4'd2;
  localparam logic [ADDR_W-1:0] A_PER    = 4'd3;
  localparam logic [ADDR_W-1:0] A_MSKEN  = 4'd4;
  localparam logic [ADDR_W-1:0] A_MSKLVL = 4'd5;
  localparam logic [ADDR_W-1:0] A_LOAD   = 4'd6;
  localparam logic [ADDR_W-1:0] A_IRQCLR = 4'd7;
  localparam logic [ADDR_W-1:0] A_CMP0   = 4'd8;

  function automatic logic [PS_W-1:0] div_last(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd0;
      2'd1:    return 4'd1;
      2'd2:    return 4'd3;
      default: return 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pair_pkg::*;
#(
  parameter int unsigned NCH = 6,
  parameter int unsigned CW  = 16,
  localparam int unsigned NPAIR = NCH / 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [CW-1:0]              wr_data_i,
  input  logic                       load_ack_i,
  input  logic                       irq_ev_i,
  output cfg_t                       cfg_o,
  output logic [NCH-1:0]             run_o,
  output logic [NCH-1:0]             oen_o,
  output logic [NCH-1:0]             msk_en_o,
  output logic [NCH-1:0]             msk_lvl_o,
  output logic [CW-1:0]              per_buf_o,
  output logic [NPAIR-1:0][CW-1:0]   cmp_buf_o,
  output logic                       load_pend_o,
  output logic                       irq_o
);
  logic wr_load, wr_clr;

  assign wr_load = wr_en_i && (wr_addr_i == A_LOAD);
  assign wr_clr  = wr_en_i && (wr_addr_i == A_IRQCLR) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o     <= '0;
      run_o     <= '0;
      oen_o     <= '0;
      msk_en_o  <= '0;
      msk_lvl_o <= '0;
      per_buf_o <= '0;
      cmp_buf_o <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CFG:    cfg_o     <= cfg_t'(wr_data_i[$bits(cfg_t)-1:0]);
        A_RUN:    run_o     <= wr_data_i[NCH-1:0];
        A_OEN:    oen_o     <= wr_data_i[NCH-1:0];
        A_MSKEN:  msk_en_o  <= wr_data_i[NCH-1:0];
        A_MSKLVL: msk_lvl_o <= wr_data_i[NCH-1:0];
        A_PER:    per_buf_o <= wr_data_i;
        default: begin
          for (int k = 0; k < NPAIR; k++) begin
            if (wr_addr_i == ADDR_W'(A_CMP0 + k)) cmp_buf_o[k] <= wr_data_i;
          end
        end
      endcase
    end
  end

  // load request waits for the counter's zero point
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         load_pend_o <= 1'b0;
    else if (wr_load)    load_pend_o <= 1'b1;
    else if (load_ack_i) load_pend_o <= 1'b0;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_o <= 1'b0;
    else if (irq_ev_i) irq_o <= 1'b1;
    else if (wr_clr)   irq_o <= 1'b0;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pair_pkg::*;
#(
  parameter int unsigned NPAIR = 3,
  parameter int unsigned CW    = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     run_i,
  input  logic [1:0]               div_i,
  input  logic                     center_i,
  input  logic                     on_match_i,
  input  logic                     load_pend_i,
  input  logic [CW-1:0]            per_buf_i,
  input  logic [NPAIR-1:0][CW-1:0] cmp_buf_i,
  output logic [CW-1:0]            cnt_o,
  output logic [CW-1:0]            per_act_o,
  output logic [NPAIR-1:0][CW-1:0] cmp_act_o,
  output logic                     tick_o,
  output logic                     load_ack_o,
  output logic                     irq_ev_o
);
  logic [PS_W-1:0] pcnt_q;
  logic            up_q;
  logic [CW-1:0]   cnt_q, per_q, per_nxt;
  logic            at_zero, peak, down_step, match_ev, under_ev;

  assign tick_o     = run_i && (pcnt_q == div_last(div_i));
  assign at_zero    = (cnt_q == '0);
  assign per_nxt    = load_pend_i ? per_buf_i : per_q;
  assign peak       = up_q && (cnt_q >= per_q);
  assign down_step  = !at_zero && (!center_i || !up_q || peak);
  assign load_ack_o = tick_o && at_zero && load_pend_i;
  assign match_ev   = tick_o && (per_q != '0) && (cnt_q == per_q);
  assign under_ev   = tick_o && down_step && (cnt_q == CW'(1));
  assign irq_ev_o   = on_match_i ? match_ev : under_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
      up_q   <= 1'b0;
    end else if (!run_i) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
      up_q   <= 1'b0;
    end else begin
      pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
      if (tick_o) begin
        if (at_zero) begin
          if (center_i) begin
            cnt_q <= (per_nxt != '0) ? CW'(1) : '0;
            up_q  <= (per_nxt != '0);
          end else begin
            cnt_q <= per_nxt;
            up_q  <= 1'b0;
          end
        end else if (down_step) begin
          cnt_q <= cnt_q - 1'b1;
          if (peak) up_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // shadow registers update only at the zero point
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q     <= '0;
      cmp_act_o <= '0;
    end else if (load_ack_o) begin
      per_q     <= per_buf_i;
      cmp_act_o <= cmp_buf_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign per_act_o = per_q;
endmodule

// File: rtl/pwm_out.sv
module pwm_out
  import pwm_pair_pkg::*;
#(
  parameter int unsigned NCH = 6,
  parameter int unsigned CW  = 16,
  localparam int unsigned NPAIR = NCH / 2
) (
  input  logic [CW-1:0]            cnt_i,
  input  logic [NPAIR-1:0][CW-1:0] cmp_i,
  input  pair_mode_e               mode_i,
  input  logic [NCH-1:0]           en_i,
  input  logic [NCH-1:0]           msk_en_i,
  input  logic [NCH-1:0]           msk_lvl_i,
  input  logic                     invert_i,
  output logic [NCH-1:0]           pwm_o
);
  logic [NCH-1:0] wave;

  function automatic logic odd_wave(input pair_mode_e m, input logic raw,
                                    input logic en_odd, input logic even);
    case (m)
      MODE_COMPL: return ~raw & en_odd;
      MODE_SYNC:  return even;
      default:    return raw & en_odd;
    endcase
  endfunction

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    logic raw;
    assign raw          = (cnt_i <= cmp_i[k]);
    assign wave[2*k]    = raw & en_i[2*k];
    assign wave[2*k+1]  = odd_wave(mode_i, raw, en_i[2*k+1], wave[2*k]);
  end

  assign pwm_o = ((wave & ~msk_en_i) | (msk_lvl_i & msk_en_i)) ^ {NCH{invert_i}};
endmodule

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen
  import pwm_pair_pkg::*;
#(
  parameter int unsigned NCH = 6,
  parameter int unsigned CW  = 16,
  localparam int unsigned NPAIR = NCH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CW-1:0]     wr_data_i,
  output logic [NCH-1:0]    pwm_o,
  output logic              irq_o
);
  cfg_t                     cfg;
  logic [NCH-1:0]           run, oen, en, msk_en, msk_lvl;
  logic [CW-1:0]            per_buf, per_act, cnt;
  logic [NPAIR-1:0][CW-1:0] cmp_buf, cmp_act;
  logic                     load_pend, load_ack, irq_ev, tick, run_any;

  assign en      = run & oen;
  assign run_any = |run;

  pwm_regs #(.NCH(NCH), .CW(CW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_ack_i (load_ack),
    .irq_ev_i   (irq_ev),
    .cfg_o      (cfg),
    .run_o      (run),
    .oen_o      (oen),
    .msk_en_o   (msk_en),
    .msk_lvl_o  (msk_lvl),
    .per_buf_o  (per_buf),
    .cmp_buf_o  (cmp_buf),
    .load_pend_o(load_pend),
    .irq_o
  );

  pwm_counter #(.NPAIR(NPAIR), .CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .run_i      (run_any),
    .div_i      (cfg.div),
    .center_i   (cfg.center),
    .on_match_i (cfg.irq_on_match),
    .load_pend_i(load_pend),
    .per_buf_i  (per_buf),
    .cmp_buf_i  (cmp_buf),
    .cnt_o      (cnt),
    .per_act_o  (per_act),
    .cmp_act_o  (cmp_act),
    .tick_o     (tick),
    .load_ack_o (load_ack),
    .irq_ev_o   (irq_ev)
  );

  pwm_out #(.NCH(NCH), .CW(CW)) u_out (
    .cnt_i    (cnt),
    .cmp_i    (cmp_act),
    .mode_i   (cfg.mode),
    .en_i     (en),
    .msk_en_i (msk_en),
    .msk_lvl_i(msk_lvl),
    .invert_i (cfg.invert),
    .pwm_o
  );
endmodule

// File: rtl/pwm_pair_gen_chk.sv
module pwm_pair_gen_chk
  import pwm_pair_pkg::*;
#(
  parameter int unsigned NCH = 6,
  parameter int unsigned CW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           clr_wr_i,
  input logic           tick_i,
  input logic [1:0]     div_i,
  input logic           run_any_i,
  input logic [1:0]     en_i,
  input logic [CW-1:0]  cnt_i,
  input logic [CW-1:0]  per_act_i,
  input logic           load_pend_i,
  input pair_mode_e     mode_i,
  input logic [NCH-1:0] msk_en_i,
  input logic [NCH-1:0] msk_lvl_i,
  input logic           invert_i,
  input logic           irq_ev_i,
  input logic           irq_o,
  input logic [NCH-1:0] pwm_o
);
  p_div_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && div_i != 2'd0) |=> !tick_i);

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= per_act_i);

  p_shadow_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_act_i) |-> $past(cnt_i) == '0);

  p_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_act_i == '0 && !load_pend_i) |=> cnt_i == '0);

  p_compl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_COMPL && en_i == 2'b11 && msk_en_i[1:0] == 2'b00) |-> pwm_o[1] != pwm_o[0]);

  p_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SYNC && msk_en_i[1:0] == 2'b00) |-> pwm_o[1] == pwm_o[0]);

  p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_any_i && msk_en_i == '0 && !invert_i) |-> pwm_o == '0);

  p_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwm_o ^ {NCH{invert_i}}) & msk_en_i) == (msk_lvl_i & msk_en_i));

  p_irq_rise_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_ev_i));

  p_irq_set_wins_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ev_i |=> irq_o);

  p_irq_clear_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && !irq_ev_i) |=> !irq_o);
endmodule

bind pwm_pair_gen pwm_pair_gen_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_wr_i   (wr_en_i && (wr_addr_i == A_IRQCLR) && wr_data_i[0]),
  .tick_i     (tick),
  .div_i      (cfg.div),
  .run_any_i  (run_any),
  .en_i       (en[1:0]),
  .cnt_i      (cnt),
  .per_act_i  (per_act),
  .load_pend_i(load_pend),
  .mode_i     (cfg.mode),
  .msk_en_i   (msk_en),
  .msk_lvl_i  (msk_lvl),
  .invert_i   (cfg.invert),
  .irq_ev_i   (irq_ev),
  .irq_o      (irq_o),
  .pwm_o      (pwm_o)
);

// File: tb/pwm_pair_gen_test.sv
`timescale 1ns/1ps
module pwm_pair_gen_test;
  import pwm_pair_pkg::*;
  localparam int NCH = 6;
  localparam int CW  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [3:0]     wr_addr = '0;
  logic [CW-1:0]  wr_data = '0;
  logic [NCH-1:0] pwm;
  logic           irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int hi[NCH];

  always #2 clk = ~clk;

  pwm_pair_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_o(pwm), .irq_o(irq)
  );

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int n);
    foreach (hi[i]) hi[i] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) if (pwm[i]) hi[i]++;
    end
  endtask

  function automatic int dfac(input int div);
    return (div == 0) ? 1 : (div == 1) ? 2 : (div == 2) ? 4 : 16;
  endfunction

  function automatic int per_len(input int center, input int p, input int div);
    return center ? 2 * p * dfac(div) : (p + 1) * dfac(div);
  endfunction

  function automatic int hi_len(input int center, input int p, input int c, input int div);
    if (center) return ((c >= p) ? 2 * p : 2 * c + 1) * dfac(div);
    return (((c >= p) ? p : c) + 1) * dfac(div);
  endfunction

  task automatic setup(input int center, input int div, input int mode, input bit irqm,
                       input bit inv, input int p, input int c0, input int c1, input int c2,
                       input logic [5:0] oen);
    logic [15:0] cfgw;
    cfgw = {9'd0, inv, irqm, 2'(mode), center[0], 2'(div)};
    wr(A_RUN, 16'd0);
    wr(A_CFG, cfgw);
    wr(A_PER, 16'(p));
    wr(A_CMP0, 16'(c0));
    wr(A_CMP0 + 4'd1, 16'(c1));
    wr(A_CMP0 + 4'd2, 16'(c2));
    wr(A_LOAD, 16'd1);
    wr(A_OEN, {10'd0, oen});
    wr(A_RUN, 16'h003f);
    repeat (2 * per_len(center, p, div) + 20) @(negedge clk);
  endtask

  task automatic wait_rise0();
    logic prev;
    prev = pwm[0];
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!prev && pwm[0]) break;
      prev = pwm[0];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int pv[3];
    pv = '{1, 3, 6};
    repeat (3) @(negedge clk);
    chk("R1 pwm in reset", int'(pwm), 0);
    chk("R1 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk("R1 pwm idle after reset", int'(pwm), 0);
    chk("R1 irq idle after reset", int'(irq), 0);

    // sweep: mode x counting type x prescale x period
    for (int mode = 0; mode < 3; mode++)
      for (int center = 0; center < 2; center++)
        for (int div = 0; div < 4; div++)
          for (int pi = 0; pi < 3; pi++) begin
            int p, w;
            int c[3];
            p = pv[pi];
            c[0] = 0; c[1] = (p + 1) / 2; c[2] = p + (pi % 2) * 2;
            setup(center, div, mode, 1'b0, 1'b0, p, c[0], c[1], c[2], 6'h3f);
            w = 3 * per_len(center, p, div);
            measure(w);
            for (int n = 0; n < NCH; n++) begin
              int ev, ex;
              ev = 3 * hi_len(center, p, c[n/2], div);
              ex = (n % 2 == 0) ? ev : (mode == 1) ? w - ev : ev;
              chk($sformatf("%s ch%0d mode%0d div%0d P%0d",
                            center ? "R4 R2 R5 R8" : "R3 R2 R5 R8", n, mode, div, p),
                  hi[n], ex);
            end
          end

    // R6 buffered writes need a load
    setup(0, 0, 0, 1'b0, 1'b0, 6, 2, 2, 2, 6'h3f);
    measure(21);
    chk("R6 base duty", hi[0], 9);
    wr(A_CMP0, 16'd5);
    wr(A_PER, 16'd3);
    repeat (20) @(negedge clk);
    measure(21);
    chk("R6 no load ch0", hi[0], 9);
    chk("R6 no load ch2 period", hi[2], 9);
    wr(A_PER, 16'd6);
    wr(A_LOAD, 16'd1);
    repeat (20) @(negedge clk);
    measure(21);
    chk("R6 after load", hi[0], 18);

    // R7 period 0 holds counter at 0 (C=0 then always high)
    setup(0, 0, 0, 1'b0, 1'b0, 6, 0, 0, 0, 6'h3f);
    measure(21);
    chk("R7 running duty", hi[0], 3);
    wr(A_PER, 16'd0);
    wr(A_LOAD, 16'd1);
    repeat (20) @(negedge clk);
    measure(40);
    chk("R7 stopped ch0", hi[0], 40);
    chk("R7 stopped ch1", hi[1], 40);

    // R9 gating and R8 sync follow
    setup(0, 0, 2, 1'b0, 1'b0, 6, 2, 2, 2, 6'h01);
    measure(21);
    chk("R9 ch0 enabled", hi[0], 9);
    chk("R8 sync ch1 follows ch0", hi[1], 9);
    chk("R9 ch2 disabled", hi[2], 0);
    setup(0, 0, 0, 1'b0, 1'b0, 6, 2, 2, 2, 6'h01);
    measure(21);
    chk("R9 indep ch1 disabled", hi[1], 0);
    wr(A_OEN, 16'h003f);
    wr(A_RUN, 16'h0002);
    measure(21);
    chk("R9 run clear ch0", hi[0], 0);
    chk("R9 run set ch1", hi[1], 9);
    wr(A_RUN, 16'h0000);
    repeat (5) @(negedge clk);
    chk("R9 all stopped", int'(pwm), 0);

    // R10 mask, R11 invert after mask
    setup(0, 0, 0, 1'b0, 1'b0, 6, 2, 2, 2, 6'h3f);
    wr(A_MSKEN, 16'h0021);
    wr(A_MSKLVL, 16'h0020);
    measure(21);
    chk("R10 ch0 forced low", hi[0], 0);
    chk("R10 ch5 forced high", hi[5], 21);
    chk("R10 ch2 unmasked", hi[2], 9);
    wr(A_CFG, 16'h0040);
    measure(21);
    chk("R11 ch0 masked inverted", hi[0], 21);
    chk("R11 ch5 masked inverted", hi[5], 0);
    chk("R11 ch2 inverted", hi[2], 12);
    wr(A_MSKEN, 16'h0000);
    wr(A_CFG, 16'h0000);

    // R12 underflow flag, R13 clear and set-wins
    setup(0, 0, 0, 1'b0, 1'b0, 20, 0, 0, 0, 6'h3f);
    wait_rise0();
    wr(A_IRQCLR, 16'd1);
    chk("R13 clear", int'(irq), 0);
    repeat (19) @(negedge clk);
    chk("R12 before underflow irq", int'(irq), 0);
    chk("R12 before underflow pwm", int'(pwm[0]), 0);
    @(negedge clk);
    chk("R12 underflow irq", int'(irq), 1);
    chk("R12 underflow pwm", int'(pwm[0]), 1);
    repeat (20) @(negedge clk);
    wr(A_IRQCLR, 16'd1);
    chk("R13 set wins over clear", int'(irq), 1);
    wr(A_IRQCLR, 16'd1);
    chk("R13 clear after set", int'(irq), 0);

    // R12 match-with-period flag
    setup(0, 0, 0, 1'b1, 1'b0, 20, 0, 0, 0, 6'h3f);
    wait_rise0();
    wr(A_IRQCLR, 16'd1);
    chk("R12 match not yet", int'(irq), 0);
    @(negedge clk);
    chk("R12 match sets", int'(irq), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule